// File: doc/BRIEF.md
# SD Ping-Pong Data Buffer

This block sits in the data path of an SD/SDIO host controller, between a 32-bit word interface on the host side and an 8-bit byte interface that feeds or is fed by the card-side serial engine. It holds two block-sized buffers, each 512 bytes by default. Each buffer has its own write and read port. At any moment a buffer belongs either to the side that produces data or to the side that consumes it. The producer fills one buffer while the consumer empties the other, and the two swap roles at block boundaries. The same pair serves both directions. In a write transfer, the host produces words and the card engine consumes bytes. In a read transfer, the card engine produces bytes and the host consumes words, with four bytes packed per word.

A transfer begins with a start pulse, and the direction input is sampled on that pulse. A buffer passes to the consumer when its last byte slot is written, or when the end-of-transfer strobe seals a partly filled buffer. After the end strobe the block stops taking new data. It lets the consumer empty whatever is still sealed, then goes idle. In a read transfer, when both buffers wait on the host, the block raises a clock-stop request so the card engine halts the card clock until the host hands a buffer back.

The control is a four-state machine with these transitions:
- IDLE to WRITE: a start pulse arrives with the direction low.
- IDLE to READ: a start pulse arrives with the direction high.
- WRITE or READ to FLUSH: the end strobe arrives.
- FLUSH to IDLE: both buffers are back with the producer and empty.

The fill and drain selectors are reset to buffer 0 on the IDLE-to-WRITE and IDLE-to-READ transitions. After that they change only when a buffer is handed over.

Top module: `sd_pingpong_buf`

## Requirements
- R1: After reset the block is idle:
  - `h_wready`, `c_rready`, `c_tvalid`, `h_rvalid`, `card_clk_stop` and both error flags are 0.
  - `buf_empty` is 2'b11 and `buf_full` is 2'b00.
- R2: In a write transfer (`xfer_dir`=0 at start), the card side delivers the host's bytes in the order written. Within a word, bits 7:0 come out first and bits 31:24 last. Buffers are filled and drained alternately, starting with buffer 0.
- R3: A buffer passes to the consumer as soon as its 512th byte is written. The host may then fill the other buffer while the card drains the first. With both buffers full and card-owned, `h_wready` is 0.
- R4: In a read transfer (`xfer_dir`=1 at start), the host receives card bytes packed four per word, with the earliest byte in bits 7:0. Blocks are presented in the order the card filled them.
- R5: While a read transfer is in READ and both buffers are held by the host, `card_clk_stop` is 1 and `c_rready` is 0. At the first clock edge where the host reads the last word of a buffer, `card_clk_stop` falls to 0.
- R6: The fill and drain positions are kept through a clock-stop period. No byte is lost or repeated across the stall.
- R7: An end strobe seals a partly filled producer buffer, and the consumer receives exactly the bytes written into it. In a read, the bytes of the final word beyond the last card byte read as 0. Once everything sealed has been drained, the block returns to idle with both buffers empty.
- R8: The direction is fixed for the whole transfer. A start pulse with a different `xfer_dir` during a transfer is ignored, and only one side's producer and consumer handshakes are ever active.
- R9: `buf_empty[i]` is 1 when buffer i holds no bytes, and `buf_full[i]` is 1 when it holds 512. `buf_card_own[i]` is 1 when buffer i is on the card side: the consumer in a write, the producer in a read.
- R10: `err_wr_full` sets when, in WRITE, `h_wvalid` is 1 while `h_wready` is 0. It stays set until `err_clr`.
- R11: `err_rd_empty` sets when, during a read transfer, `h_rready` is 1 while `h_rvalid` is 0. It stays set until `err_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start pulse, honoured in IDLE only |
| xfer_dir | input | 1 | Direction sampled at start: 0 host-to-card, 1 card-to-host |
| xfer_end | input | 1 | End-of-transfer strobe |
| err_clr | input | 1 | Clears both sticky error flags |
| h_wdata | input | 32 | Host write word |
| h_wvalid | input | 1 | Host write word valid |
| h_wready | output | 1 | Block accepts a host word |
| h_rdata | output | 32 | Host read word |
| h_rvalid | output | 1 | Host read word available |
| h_rready | input | 1 | Host takes the read word |
| c_tdata | output | 8 | Byte toward the card engine |
| c_tvalid | output | 1 | Byte toward the card available |
| c_tready | input | 1 | Card engine takes the byte |
| c_rdata | input | 8 | Byte from the card engine |
| c_rvalid | input | 1 | Card byte valid |
| c_rready | output | 1 | Block accepts a card byte |
| card_clk_stop | output | 1 | Request to halt the card clock |
| buf_empty | output | 2 | Per-buffer empty status |
| buf_full | output | 2 | Per-buffer full status |
| buf_card_own | output | 2 | Per-buffer card-side ownership |
| err_rd_empty | output | 1 | Sticky: host read tried with no data |
| err_wr_full | output | 1 | Sticky: host write tried with no space |

## Verification
The assertions assume the following about the environment:
- A producer only drives its valid when the matching ready is high, so handshakes never pile up against a stalled buffer.
- The end strobe arrives only after the producer has finished, and never in a cycle when a producer beat is offered.
- Reset is held low from time zero.

The stimulus respects these assumptions. It waits for the ready outputs to settle after each input change and only then raises `h_wvalid`, `c_rvalid` or `h_rready`. The only deliberate breaches are the single offending beats used to set the error flags. Random stall patterns drawn from a fixed seed vary how the two sides overlap. Directed holds force both buffers full in each direction, and odd byte counts exercise the partly filled final block.

// File: rtl/sdpp_pkg.sv
package sdpp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_FLUSH = 2'd3
    } sdpp_state_e;

    localparam logic DIR_TO_CARD = 1'b0;
    localparam logic DIR_TO_HOST = 1'b1;

endpackage

// File: rtl/sdpp_fsm.sv
module sdpp_fsm
    import sdpp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start,
    input  logic xfer_dir,
    input  logic xfer_end,
    input  logic both_free,
    input  logic both_held,
    output logic dir_q,
    output logic prod_en,
    output logic cons_en,
    output logic end_seal,
    output logic sel_clear,
    output logic clk_stop,
    output logic wr_phase,
    output logic rd_side
);

    sdpp_state_e state_q, state_d;

    // state register and direction latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_TO_CARD;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && xfer_start)
                dir_q <= xfer_dir;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_start)
                    state_d = (xfer_dir == DIR_TO_HOST) ? ST_READ : ST_WRITE;
            end
            ST_WRITE, ST_READ: begin
                if (xfer_end)
                    state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (both_free)
                    state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        prod_en   = 1'b0;
        cons_en   = 1'b0;
        end_seal  = 1'b0;
        sel_clear = 1'b0;
        clk_stop  = 1'b0;
        wr_phase  = 1'b0;
        rd_side   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                sel_clear = xfer_start;
            end
            ST_WRITE: begin
                prod_en  = !xfer_end;
                cons_en  = 1'b1;
                end_seal = xfer_end;
                wr_phase = 1'b1;
            end
            ST_READ: begin
                prod_en  = !xfer_end;
                cons_en  = 1'b1;
                end_seal = xfer_end;
                clk_stop = both_held;
                rd_side  = 1'b1;
            end
            ST_FLUSH: begin
                cons_en = 1'b1;
                rd_side = dir_q;
            end
        endcase
    end

endmodule

// File: rtl/sdpp_bank.sv
module sdpp_bank #(
    parameter int BLK_BYTES  = 512,
    parameter int HOST_BYTES = 4,
    localparam int AW = $clog2(BLK_BYTES),
    localparam int CW = $clog2(BLK_BYTES + 1),
    localparam int HW = 8 * HOST_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_wide,
    input  logic [HW-1:0] wr_data,
    input  logic          seal,
    input  logic          rd_en,
    input  logic          rd_wide,
    output logic          cons_own,
    output logic [CW-1:0] count,
    output logic [HW-1:0] rd_word,
    output logic [7:0]    rd_byte,
    output logic          seal_evt,
    output logic          rel_evt
);

    logic [7:0]    mem [BLK_BYTES];
    logic [CW-1:0] cnt_q, rdp_q, wr_n, rd_n;
    logic          own_q;

    assign wr_n     = wr_wide ? CW'(HOST_BYTES) : CW'(1);
    assign rd_n     = rd_wide ? CW'(HOST_BYTES) : CW'(1);
    assign seal_evt = (wr_en && (cnt_q + wr_n == CW'(BLK_BYTES))) || seal;
    assign rel_evt  = rd_en && ((rdp_q + rd_n) >= cnt_q);
    assign cons_own = own_q;
    assign count    = cnt_q;

    // ownership, fill count and drain pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rdp_q <= '0;
            own_q <= 1'b0;
        end else begin
            if (wr_en)
                cnt_q <= cnt_q + wr_n;
            if (seal_evt)
                own_q <= 1'b1;
            if (rd_en) begin
                if (rel_evt) begin
                    own_q <= 1'b0;
                    cnt_q <= '0;
                    rdp_q <= '0;
                end else begin
                    rdp_q <= rdp_q + rd_n;
                end
            end
        end
    end

    // storage: one byte lane per host byte
    always_ff @(posedge clk) begin
        for (int k = 0; k < HOST_BYTES; k++) begin
            if (wr_en && (k == 0 || wr_wide))
                mem[AW'(cnt_q + CW'(k))] <= wr_data[k*8 +: 8];
        end
    end

    // read side: bytes past the fill count read as zero
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < HOST_BYTES; k++) begin
            if ((rdp_q + CW'(k)) < cnt_q)
                rd_word[k*8 +: 8] = mem[AW'(rdp_q + CW'(k))];
        end
        rd_byte = mem[AW'(rdp_q)];
    end

endmodule

// File: rtl/sd_pingpong_buf.sv
module sd_pingpong_buf
    import sdpp_pkg::*;
#(
    parameter int BLK_BYTES  = 512,
    parameter int HOST_BYTES = 4,
    localparam int CW = $clog2(BLK_BYTES + 1),
    localparam int HW = 8 * HOST_BYTES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_start,
    input  logic          xfer_dir,
    input  logic          xfer_end,
    input  logic          err_clr,
    input  logic [HW-1:0] h_wdata,
    input  logic          h_wvalid,
    output logic          h_wready,
    output logic [HW-1:0] h_rdata,
    output logic          h_rvalid,
    input  logic          h_rready,
    output logic [7:0]    c_tdata,
    output logic          c_tvalid,
    input  logic          c_tready,
    input  logic [7:0]    c_rdata,
    input  logic          c_rvalid,
    output logic          c_rready,
    output logic          card_clk_stop,
    output logic [1:0]    buf_empty,
    output logic [1:0]    buf_full,
    output logic [1:0]    buf_card_own,
    output logic          err_rd_empty,
    output logic          err_wr_full
);

    logic          dir_q, prod_en, cons_en, end_seal, sel_clear, wr_phase, rd_side;
    logic          fill_sel, drain_sel;
    logic          prod_ok, cons_ok, prod_fire, cons_fire;
    logic [1:0]    own, seal_evt, rel_evt, wr_en, rd_en, seal;
    logic [CW-1:0] bank_cnt  [2];
    logic [HW-1:0] bank_word [2];
    logic [7:0]    bank_byte [2];
    logic [HW-1:0] wr_data;

    sdpp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_dir   (xfer_dir),
        .xfer_end   (xfer_end),
        .both_free  (own == 2'b00),
        .both_held  (own == 2'b11),
        .dir_q      (dir_q),
        .prod_en    (prod_en),
        .cons_en    (cons_en),
        .end_seal   (end_seal),
        .sel_clear  (sel_clear),
        .clk_stop   (card_clk_stop),
        .wr_phase   (wr_phase),
        .rd_side    (rd_side)
    );

    // producer side: host words in a write, card bytes in a read
    assign prod_ok   = prod_en && !own[fill_sel];
    assign h_wready  = prod_ok && (dir_q == DIR_TO_CARD);
    assign c_rready  = prod_ok && (dir_q == DIR_TO_HOST);
    assign prod_fire = (dir_q == DIR_TO_HOST) ? (c_rvalid && c_rready)
                                              : (h_wvalid && h_wready);
    assign wr_data   = (dir_q == DIR_TO_HOST) ? {{(HW-8){1'b0}}, c_rdata} : h_wdata;

    // consumer side: card bytes in a write, host words in a read
    assign cons_ok   = cons_en && own[drain_sel];
    assign c_tvalid  = cons_ok && (dir_q == DIR_TO_CARD);
    assign h_rvalid  = cons_ok && (dir_q == DIR_TO_HOST);
    assign cons_fire = (dir_q == DIR_TO_HOST) ? (h_rvalid && h_rready)
                                              : (c_tvalid && c_tready);
    assign c_tdata   = bank_byte[drain_sel];
    assign h_rdata   = bank_word[drain_sel];

    for (genvar gi = 0; gi < 2; gi++) begin : g_bank
        assign wr_en[gi] = prod_fire && (fill_sel == 1'(gi));
        assign rd_en[gi] = cons_fire && (drain_sel == 1'(gi));
        assign seal[gi]  = end_seal && (fill_sel == 1'(gi)) && !own[gi]
                           && (bank_cnt[gi] != '0);

        sdpp_bank #(
            .BLK_BYTES  (BLK_BYTES),
            .HOST_BYTES (HOST_BYTES)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[gi]),
            .wr_wide  (dir_q == DIR_TO_CARD),
            .wr_data  (wr_data),
            .seal     (seal[gi]),
            .rd_en    (rd_en[gi]),
            .rd_wide  (dir_q == DIR_TO_HOST),
            .cons_own (own[gi]),
            .count    (bank_cnt[gi]),
            .rd_word  (bank_word[gi]),
            .rd_byte  (bank_byte[gi]),
            .seal_evt (seal_evt[gi]),
            .rel_evt  (rel_evt[gi])
        );

        assign buf_empty[gi]    = (bank_cnt[gi] == '0);
        assign buf_full[gi]     = (bank_cnt[gi] == CW'(BLK_BYTES));
        assign buf_card_own[gi] = (dir_q == DIR_TO_HOST) ? !own[gi] : own[gi];
    end

    // alternation pointers: move only on hand-over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sel  <= 1'b0;
            drain_sel <= 1'b0;
        end else if (sel_clear) begin
            fill_sel  <= 1'b0;
            drain_sel <= 1'b0;
        end else begin
            if (seal_evt[fill_sel])
                fill_sel <= !fill_sel;
            if (rel_evt[drain_sel])
                drain_sel <= !drain_sel;
        end
    end

    // sticky misuse flags, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_wr_full  <= 1'b0;
            err_rd_empty <= 1'b0;
        end else begin
            err_wr_full  <= (err_wr_full && !err_clr) || (wr_phase && h_wvalid && !h_wready);
            err_rd_empty <= (err_rd_empty && !err_clr) || (rd_side && h_rready && !h_rvalid);
        end
    end

endmodule

// File: rtl/sdpp_checker.sv
module sdpp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       err_clr,
    input logic       h_wready,
    input logic       h_rvalid,
    input logic       c_tvalid,
    input logic       c_rready,
    input logic       card_clk_stop,
    input logic [1:0] buf_empty,
    input logic       err_rd_empty,
    input logic       err_wr_full
);

    p_stop_blocks_card_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_clk_stop |-> (!c_rready && h_rvalid))
        else $error("card clock stop without full host-held buffers");

    p_single_producer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_wready && c_rready))
        else $error("both producer handshakes open");

    p_single_consumer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_tvalid && h_rvalid))
        else $error("both consumer handshakes open");

    p_card_data_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
        c_tvalid |-> (buf_empty != 2'b11))
        else $error("card byte offered from empty buffers");

    p_wr_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wr_full && !err_clr) |=> err_wr_full)
        else $error("write-full flag dropped without clear");

    p_rd_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rd_empty && !err_clr) |=> err_rd_empty)
        else $error("read-empty flag dropped without clear");

endmodule

bind sd_pingpong_buf sdpp_checker u_sdpp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_clr       (err_clr),
    .h_wready      (h_wready),
    .h_rvalid      (h_rvalid),
    .c_tvalid      (c_tvalid),
    .c_rready      (c_rready),
    .card_clk_stop (card_clk_stop),
    .buf_empty     (buf_empty),
    .err_rd_empty  (err_rd_empty),
    .err_wr_full   (err_wr_full)
);

// File: tb/sd_pingpong_buf_test.sv
module sd_pingpong_buf_test;

    localparam int CLK_PERIOD = 10;
    localparam int BLK        = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_dir = 1'b0, xfer_end = 1'b0, err_clr = 1'b0;
    logic [31:0] h_wdata = '0;
    logic        h_wvalid = 1'b0, h_rready = 1'b0;
    logic [7:0]  c_rdata = '0;
    logic        c_rvalid = 1'b0, c_tready = 1'b0;
    logic        h_wready, h_rvalid, c_tvalid, c_rready, card_clk_stop;
    logic [31:0] h_rdata;
    logic [7:0]  c_tdata;
    logic [1:0]  buf_empty, buf_full, buf_card_own;
    logic        err_rd_empty, err_wr_full;

    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_pingpong_buf uut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_dir(xfer_dir),
        .xfer_end(xfer_end), .err_clr(err_clr), .h_wdata(h_wdata), .h_wvalid(h_wvalid),
        .h_wready(h_wready), .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_rready(h_rready),
        .c_tdata(c_tdata), .c_tvalid(c_tvalid), .c_tready(c_tready), .c_rdata(c_rdata),
        .c_rvalid(c_rvalid), .c_rready(c_rready), .card_clk_stop(card_clk_stop),
        .buf_empty(buf_empty), .buf_full(buf_full), .buf_card_own(buf_card_own),
        .err_rd_empty(err_rd_empty), .err_wr_full(err_wr_full)
    );

    task automatic check(input logic ok, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] pack_word(input int n);
        logic [31:0] w = '0;
        for (int k = 0; k < n; k++) w[k*8 +: 8] = exp_q.pop_front();
        return w;
    endfunction

    task automatic quiet_inputs();
        xfer_start = 0; xfer_dir = 0; xfer_end = 0; err_clr = 0;
        h_wvalid = 0; h_rready = 0; c_rvalid = 0; c_tready = 0;
    endtask

    task automatic start_xfer(input logic dir);
        @(negedge clk);
        xfer_start = 1; xfer_dir = dir;
        @(negedge clk);
        xfer_start = 0; xfer_dir = 0;
    endtask

    task automatic check_idle(input string tag);
        repeat (3) @(negedge clk);
        check(!h_wready && !c_rready && !c_tvalid && !h_rvalid && !card_clk_stop,
              {tag, " handshakes idle after flush"},
              {h_wready, c_rready, c_tvalid, h_rvalid, card_clk_stop}, 0);
        check(buf_empty == 2'b11, {tag, " both buffers empty"}, buf_empty, 2'b11);
    endtask

    // host-to-card transfer with random stalls on both sides
    task automatic run_write(input int nwords, input int card_hold, input string tag);
        int sent = 0, got = 0, mism = 0, conc = 0, stray = 0, cyc = 0;
        logic end_sent = 0;
        logic [31:0] w = $urandom;
        exp_q.delete();
        start_xfer(1'b0);
        while (!(end_sent && got == nwords*4) && cyc < 20000) begin
            cyc++;
            xfer_end   = (sent == nwords) && !end_sent;
            xfer_start = (cyc == 5);          // R8: attempt to flip direction mid-transfer
            xfer_dir   = (cyc == 5);
            c_tready   = (cyc > card_hold) && ($urandom % 3 != 0);
            #1;
            if (c_rready) stray++;
            h_wvalid = h_wready && (sent < nwords) && ($urandom % 4 != 0);
            h_wdata  = w;
            #1;
            if (h_wready && c_tvalid) conc++;
            if (c_tvalid && c_tready) begin
                if (exp_q.size() == 0) mism++;
                else if (c_tdata != exp_q.pop_front()) mism++;
                got++;
            end
            if (h_wvalid) begin
                for (int k = 0; k < 4; k++) exp_q.push_back(w[k*8 +: 8]);
                sent++;
                w = $urandom;
            end
            if (xfer_end) end_sent = 1;
            @(negedge clk);
        end
        quiet_inputs();
        check(mism == 0 && got == nwords*4, {tag, " R2 R7 card byte order"}, mism, 0);
        check(stray == 0, {tag, " R8 direction held, c_rready stayed low"}, stray, 0);
        if (nwords > BLK/4)
            check(conc > 0, {tag, " R3 host fills while card drains"}, conc, 1);
        check_idle({tag, " R7"});
    endtask

    // card-to-host transfer; host_hold forces both buffers full
    task automatic run_read(input int nbytes, input int host_hold, input string tag);
        int sent = 0, hgot = 0, mism = 0, cyc = 0, stops = 0, bad_stop = 0;
        logic end_sent = 0, pend_rel = 0, seen_stop = 0, stop_b;
        logic [7:0] b = 8'($urandom);
        exp_q.delete();
        start_xfer(1'b1);
        while (!(end_sent && hgot >= nbytes) && cyc < 20000) begin
            cyc++;
            if (pend_rel) begin
                check(!card_clk_stop, {tag, " R5 stop clears after buffer release"}, card_clk_stop, 0);
                pend_rel = 0;
            end
            xfer_end = (sent == nbytes) && !end_sent;
            #1;
            c_rvalid = c_rready && (sent < nbytes) && ($urandom % 4 != 0);
            c_rdata  = b;
            h_rready = h_rvalid && (cyc > host_hold) && ($urandom % 3 != 0);
            #1;
            stop_b = card_clk_stop;
            if (stop_b) begin
                stops++;
                if (c_rready) bad_stop++;
                if (host_hold > 0 && !seen_stop) begin
                    check(buf_full == 2'b11, {tag, " R9 both full at stop"}, buf_full, 2'b11);
                    check(buf_card_own == 2'b00, {tag, " R9 R5 both host-owned at stop"},
                          buf_card_own, 2'b00);
                end
                seen_stop = 1;
            end
            if (c_rvalid) begin
                exp_q.push_back(b);
                sent++;
                b = 8'($urandom);
            end
            if (h_rready) begin
                int n = (nbytes - hgot) < 4 ? (nbytes - hgot) : 4;
                logic [31:0] e;
                if (exp_q.size() < n) begin
                    mism++;
                    e = '0;
                end else begin
                    e = pack_word(n);
                end
                if (h_rdata != e) begin
                    if (mism == 0)
                        $display("  first mismatch at byte %0d: %0h vs %0h", hgot, h_rdata, e);
                    mism++;
                end
                hgot += n;
                if (stop_b && (hgot % BLK == 0 || hgot == nbytes)) pend_rel = 1;
            end
            if (xfer_end) end_sent = 1;
            @(negedge clk);
        end
        quiet_inputs();
        check(mism == 0 && hgot == nbytes, {tag, " R4 R6 R7 host word content"}, mism, 0);
        check(bad_stop == 0, {tag, " R5 c_rready low while stopped"}, bad_stop, 0);
        if (host_hold > 0)
            check(stops > 0, {tag, " R5 clock stop raised"}, stops, 1);
        check_idle({tag, " R7"});
    endtask

    task automatic flag_tests();
        int cyc = 0;
        // R10: fill both buffers with the card stalled
        start_xfer(1'b0);
        for (int i = 0; i < 2*BLK/4; i++) begin
            #1;
            h_wvalid = h_wready;
            h_wdata  = $urandom;
            @(negedge clk);
        end
        h_wvalid = 0;
        check(buf_full == 2'b11, "R9 both buffers full", buf_full, 2'b11);
        check(buf_card_own == 2'b11, "R3 R9 full buffers card-owned", buf_card_own, 2'b11);
        check(!h_wready, "R3 h_wready low when both full", h_wready, 0);
        check(!err_wr_full, "R10 flag clear before misuse", err_wr_full, 0);
        h_wvalid = 1;
        @(negedge clk);
        h_wvalid = 0;
        check(err_wr_full, "R10 flag set on write to full", err_wr_full, 1);
        repeat (3) @(negedge clk);
        check(err_wr_full, "R10 flag sticky", err_wr_full, 1);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        check(!err_wr_full, "R10 flag cleared", err_wr_full, 0);
        c_tready = 1;
        while (buf_empty != 2'b11 && cyc < 3000) begin
            cyc++;
            @(negedge clk);
        end
        c_tready = 0;
        xfer_end = 1;
        @(negedge clk);
        xfer_end = 0;
        check_idle("R7 full-flag test");
        // R11: host read with nothing available
        start_xfer(1'b1);
        check(!h_rvalid, "R11 nothing to read yet", h_rvalid, 0);
        h_rready = 1;
        @(negedge clk);
        h_rready = 0;
        check(err_rd_empty, "R11 flag set on read from empty", err_rd_empty, 1);
        repeat (2) @(negedge clk);
        check(err_rd_empty, "R11 flag sticky", err_rd_empty, 1);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        check(!err_rd_empty, "R11 flag cleared", err_rd_empty, 0);
        xfer_end = 1;
        @(negedge clk);
        xfer_end = 0;
        check_idle("R7 empty-flag test");
    endtask

    initial begin
        void'($urandom(32'h5D0B_1E55));
        quiet_inputs();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!h_wready && !c_rready && !c_tvalid && !h_rvalid && !card_clk_stop,
              "R1 handshakes low after reset",
              {h_wready, c_rready, c_tvalid, h_rvalid, card_clk_stop}, 0);
        check(buf_empty == 2'b11 && buf_full == 2'b00, "R1 buffers empty after reset",
              {buf_empty, buf_full}, 4'b1100);
        check(!err_rd_empty && !err_wr_full, "R1 flags clear after reset",
              {err_rd_empty, err_wr_full}, 0);

        run_write(300, 0,   "write multi-block");
        run_write(40,  200, "write short partial");
        run_write(256, 400, "write exact two blocks");
        run_read(1500, 1400, "read with clock stop");
        run_read(301,  0,    "read odd length");
        run_read(1024, 0,    "read exact two blocks");
        flag_tests();

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule